// File: doc/BRIEF.md
# Odd-Address Word Splitting Bus Sequencer

This unit sits on the master side of a 16-bit data path whose memory is byte addressed and split into two byte-wide banks: the bank holding even addresses is wired to the low data lane (bits 7:0), and the bank holding odd addresses to the high lane (bits 15:8). It accepts one byte or word request at a time, read or write, with a 20-bit byte address spanning 00000h to FFFFFh. It turns each request into one or two bus cycles and moves each byte onto the lane its address calls for.

Each bus cycle carries a 19-bit word address, an address bit 0 that acts as the even-bank select, and an active-low high-bank enable. A word whose low byte sits at an even address uses the whole 16-bit lane in a single cycle. A word starting at an odd address needs two cycles. The first moves the low byte on the high lane. The second moves the high byte on the low lane at the next address, which is even. For reads, the unit swaps the two bytes back into order before it returns the result with a one-clock completion pulse.

Top module: `lane_split_seq`

## Requirements
- R1: After reset `busy`, `bus_valid` and `done` are low.
- R2: A byte access at an even address is one bus cycle with {`bus_hbe_n`,`bus_a0`} = 10. The write byte is driven on `bus_wdata[7:0]` with the high lane zero. Read data is taken from `bus_rdata[7:0]`.
- R3: A byte access at an odd address is one bus cycle with {`bus_hbe_n`,`bus_a0`} = 01. The write byte is driven on `bus_wdata[15:8]` with the low lane zero. Read data is taken from `bus_rdata[15:8]`.
- R4: A word access at an even address is one bus cycle with {`bus_hbe_n`,`bus_a0`} = 00, carrying the full 16-bit lane unchanged.
- R5: A word access at an odd address is two back-to-back bus cycles. The first is at word address `addr[19:1]`, code 01, with the low byte on the high lane. The second is at the word address of `addr+1`, code 10, with the high byte on the low lane.
- R6: The read result is placed in `rdata` with the byte from the lower address in bits 7:0. For a word, the byte from the next address goes in bits 15:8. A byte read gives zero in bits 15:8. A write returns zero.
- R7: `done` is high for exactly one clock, in the cycle right after the last bus cycle of a request, and `rdata` is valid in that cycle.
- R8: `busy` and `bus_valid` are high exactly during the bus cycles. A request presented while `busy` is high is ignored and leaves the bus cycles of the current access unchanged.
- R9: The second cycle of an odd word at FFFFFh wraps to word address 00000h.
- R10: Code 11 on {`bus_hbe_n`,`bus_a0`} never appears while `bus_valid` is high, and `bus_we` follows the request's write flag in every bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| busy | output | 1 | High while bus cycles are running |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_waddr | output | 19 | Word address of the bus cycle |
| bus_a0 | output | 1 | Address bit 0; low selects the even bank |
| bus_hbe_n | output | 1 | Active-low enable of the odd bank |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from the banks, sampled at the end of each bus cycle |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Merged read result |

## Verification
A request sampled at a rising edge drives its first bus cycle during the next clock. An odd-address word drives its second bus cycle one clock after that. `done` and `rdata` follow one clock after the final bus cycle. The bench drives and samples on falling edges. It works out, from the address and size alone, the count of bus cycles, the lane code, the steered data and the merged result. It then checks each clock of the access in turn, including the clock after `done` to confirm the pulse has dropped. Requests injected during the bus cycles are released before the completion clock, so any reaction to them would show up in the checked cycles.

// File: rtl/lane_split_seq.sv
module lane_split_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-2:0] bus_waddr,
  output logic          bus_a0,
  output logic          bus_hbe_n,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int BW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} st_t;

  st_t           st;
  logic          op_we, op_word;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic [BW-1:0] lo_q;
  logic          done_q;
  logic [DW-1:0] rdata_q;

  logic          odd, split;
  logic [AW-1:0] next_addr, cur_addr;
  logic [DW-1:0] lane_wd;
  logic [BW-1:0] sel_lane;

  assign odd       = op_addr[0];
  assign split     = op_word & odd;
  assign next_addr = op_addr + AW'(1);
  assign sel_lane  = odd ? bus_rdata[DW-1:BW] : bus_rdata[BW-1:0];

  always_comb begin
    cur_addr  = op_addr;
    bus_hbe_n = 1'b1;
    bus_a0    = 1'b0;
    lane_wd   = '0;
    case (st)
      S_FIRST: begin
        if (op_word && !odd) begin
          bus_hbe_n = 1'b0;
          lane_wd   = op_wdata;
        end else if (odd) begin
          bus_hbe_n = 1'b0;
          bus_a0    = 1'b1;
          lane_wd   = {op_wdata[BW-1:0], {BW{1'b0}}};
        end else begin
          lane_wd   = {{BW{1'b0}}, op_wdata[BW-1:0]};
        end
      end
      S_SECOND: begin
        cur_addr = next_addr;
        lane_wd  = {{BW{1'b0}}, op_wdata[DW-1:BW]};
      end
      default: ;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign bus_valid = busy;
  assign bus_we    = busy & op_we;
  assign bus_waddr = cur_addr[AW-1:1];
  assign bus_wdata = op_we ? lane_wd : '0;
  assign done      = done_q;
  assign rdata     = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_we    <= 1'b0;
      op_word  <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      lo_q     <= '0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_we    <= req_write;
          op_word  <= req_word;
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
          st       <= S_FIRST;
        end
        S_FIRST: begin
          if (split) begin
            lo_q <= bus_rdata[DW-1:BW];
            st   <= S_SECOND;
          end else begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            rdata_q <= op_we ? '0 : (op_word ? bus_rdata : {{BW{1'b0}}, sel_lane});
          end
        end
        S_SECOND: begin
          st      <= S_IDLE;
          done_q  <= 1'b1;
          rdata_q <= op_we ? '0 : {bus_rdata[BW-1:0], lo_q};
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_split_seq_chk.sv
module lane_split_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic [AW-2:0] bus_waddr,
  input logic          bus_a0,
  input logic          bus_hbe_n,
  input logic          done
);
  // R10
  enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !(bus_hbe_n && bus_a0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_valid) && !bus_valid));

  // R5
  split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid)) |-> ($past(bus_a0) && !$past(bus_hbe_n) && !bus_a0 && bus_hbe_n));

  // R5
  split_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid)) |-> (bus_waddr == $past(bus_waddr) + 1'b1));

  // R8
  max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid)) |=> !bus_valid);
endmodule

bind lane_split_seq lane_split_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_lane_split_seq.sv
module tb_lane_split_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, bus_valid, bus_we, bus_a0, bus_hbe_n, done;
  logic [18:0] bus_waddr;
  logic [15:0] bus_wdata, bus_rdata, rdata;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lane_split_seq dut (.*);

  function automatic logic [7:0] byte_at(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  assign bus_rdata = {byte_at({bus_waddr, 1'b1}), byte_at({bus_waddr, 1'b0})};

  task automatic check(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic access(input string r, input logic we, input logic word,
                        input logic [19:0] addr, input logic [15:0] wd, input logic noise);
    logic        split;
    logic [1:0]  enc1;
    logic [15:0] wd1, exp_r;
    logic [19:0] a2;
    split = word && addr[0];
    a2 = addr + 20'd1;
    if (word && !addr[0]) begin enc1 = 2'b00; wd1 = wd; end
    else if (addr[0])     begin enc1 = 2'b01; wd1 = {wd[7:0], 8'h00}; end
    else                  begin enc1 = 2'b10; wd1 = {8'h00, wd[7:0]}; end
    exp_r = we ? 16'h0 : (word ? {byte_at(a2), byte_at(addr)} : {8'h00, byte_at(addr)});
    req_valid = 1'b1; req_write = we; req_word = word; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    if (noise) begin
      req_write = ~we; req_word = ~word; req_addr = addr ^ 20'h5A5A5; req_wdata = ~wd;
    end else req_valid = 1'b0;
    check(r, "c1 busy", {31'd0, busy}, 32'd1);
    check(r, "c1 valid", {31'd0, bus_valid}, 32'd1);
    check(r, "c1 waddr", {13'd0, bus_waddr}, {13'd0, addr[19:1]});
    check(r, "c1 enc", {30'd0, bus_hbe_n, bus_a0}, {30'd0, enc1});
    check("R10", "c1 we", {31'd0, bus_we}, {31'd0, we});
    if (we) check(r, "c1 wdata", {16'd0, bus_wdata}, {16'd0, wd1});
    check("R7", "c1 done", {31'd0, done}, 32'd0);
    if (split) begin
      @(negedge clk);
      check("R5", "c2 valid", {31'd0, bus_valid}, 32'd1);
      check("R5", "c2 waddr", {13'd0, bus_waddr}, {13'd0, a2[19:1]});
      check("R5", "c2 enc", {30'd0, bus_hbe_n, bus_a0}, 32'd2);
      check("R10", "c2 we", {31'd0, bus_we}, {31'd0, we});
      if (we) check("R5", "c2 wdata", {16'd0, bus_wdata}, {24'd0, wd[15:8]});
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R8", "end busy", {31'd0, busy}, 32'd0);
    check("R7", "done", {31'd0, done}, 32'd1);
    check("R6", "rdata", {16'd0, rdata}, {16'd0, exp_r});
    @(negedge clk);
    check("R7", "done drop", {31'd0, done}, 32'd0);
    check("R8", "idle valid", {31'd0, bus_valid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", {31'd0, busy}, 32'd0);
    check("R1", "reset valid", {31'd0, bus_valid}, 32'd0);
    check("R1", "reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    access("R2", 1'b0, 1'b0, 20'h12344, 16'h0000, 1'b0);
    access("R3", 1'b0, 1'b0, 20'h12345, 16'h0000, 1'b0);
    access("R2", 1'b1, 1'b0, 20'h0ABC2, 16'h77C3, 1'b0);
    access("R3", 1'b1, 1'b0, 20'h0ABC3, 16'h11E9, 1'b0);
    access("R4", 1'b0, 1'b1, 20'hABCDE, 16'h0000, 1'b0);
    access("R4", 1'b1, 1'b1, 20'h40000, 16'hBEEF, 1'b0);
    access("R5", 1'b0, 1'b1, 20'h3579B, 16'h0000, 1'b0);
    access("R5", 1'b1, 1'b1, 20'h00001, 16'hC0DE, 1'b0);
    access("R9", 1'b0, 1'b1, 20'hFFFFF, 16'h0000, 1'b0);
    access("R9", 1'b1, 1'b1, 20'hFFFFF, 16'h1234, 1'b0);
    access("R8", 1'b0, 1'b1, 20'h2468B, 16'h0000, 1'b1);
    access("R8", 1'b1, 1'b0, 20'h13570, 16'h00A6, 1'b1);
    access("R6", 1'b0, 1'b0, 20'hFFFFF, 16'h0000, 1'b0);
    access("R6", 1'b0, 1'b1, 20'h00000, 16'h0000, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule